// File: doc/BRIEF.md
# Programmed-IO Sample Byte Sequencer

This block lets a host move multi-byte audio samples through a single byte-wide data port. In the capture direction it takes whole samples from a capture FIFO and hands them out one byte per data-port read. In the playback direction it gathers one byte per data-port write into a sample, then pushes the finished sample into a playback FIFO. A status byte, read over the same bus, tells the host which capture byte the next data read will return. It also shows whether an unread capture sample is present and whether the playback side is still taking bytes.

Both byte pointers stop on the last byte of the sample instead of wrapping. The capture side moves on to a new sample only after two things have happened: the host has read the status byte once every byte has been consumed, and the FIFO has a sample to offer. The playback side sends its sample only after the host reads the status byte once the sample is complete. While a power-down/initialisation flag is set, the data port is frozen and reads of it return a fixed pattern.

Top module: `pio_byte_seq`

## Requirements
- R1: Each data-port read (`dat_rd_i`) returns the current capture byte on `rdata_o` in the same cycle, and the capture pointer then steps to the next byte. Bytes are ordered least significant first: byte k is `cap_sample_i[8k+7:8k]`.
- R2: While `sts_rd_i` is high, `rdata_o` carries the status byte. Bits [1:0] hold the index of the next capture byte. Bit 2 is 1 when a loaded capture sample still has unread bytes. Bit 3 is 1 when the playback side accepts bytes. Bits [7:4] are 0. After reset the status byte reads 0x08.
- R3: Once the last byte of a capture sample has been read, the pointer stays on it, and further data reads return that byte again.
- R4: A new capture sample is taken (`cap_ready_o` high together with `cap_valid_i`) at one of two times: when no sample has ever been loaded, or when the last byte has been read and a status read has followed. The pointer then returns to byte 0 and status bit 2 is set again.
- R5: If the capture FIFO offers nothing when a new sample could be taken, the pointer keeps holding the last byte until a sample arrives.
- R6: `fmt_i` sets the bytes per sample: 0 gives 1 byte (8-bit mono), 1 gives 2 bytes (16-bit mono), 2 gives 2 bytes (8-bit stereo) and 3 gives 4 bytes (16-bit stereo).
- R7: Each data-port write (`dat_wr_i`) stores `wdata_i` into the next playback byte, least significant first.
- R8: Once all bytes of a playback sample have been written, further data writes have no effect. This holds while the push is pending as well.
- R9: A status read made while the playback sample is complete raises `play_valid_o` on the next cycle. `play_sample_o` then holds the written bytes, with unused upper bytes at 0, and both signals stay steady until `play_ready_i` is high. After the handoff the playback pointer returns to byte 0 and status bit 3 is set again.
- R10: While `pdn_i` is high, data reads return 0x80 and leave the capture pointer unchanged, and data writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 2 | Sample format: bit 0 is 16-bit, bit 1 is stereo |
| pdn_i | input | 1 | Power-down/initialisation flag |
| dat_rd_i | input | 1 | Host read strobe, data port |
| dat_wr_i | input | 1 | Host write strobe, data port |
| sts_rd_i | input | 1 | Host read strobe, status port |
| wdata_i | input | 8 | Host write byte |
| rdata_o | output | 8 | Host read byte (status or capture data) |
| cap_valid_i | input | 1 | Capture FIFO has a sample |
| cap_sample_i | input | 32 | Capture FIFO sample |
| cap_ready_o | output | 1 | Capture sample taken this cycle |
| play_valid_o | output | 1 | Playback sample offered |
| play_sample_o | output | 32 | Playback sample |
| play_ready_i | input | 1 | Playback FIFO accepts the sample |

## Verification
All four formats are swept. In each format the bench reads two bytes more than the sample holds and writes two bytes more than it holds. The extra accesses separate a saturating pointer from one that wraps or runs off the end, and the byte values, which differ per format and per position, expose a wrong byte order. One capture sequence keeps a new sample waiting before the status read: this separates a reload gated by the status read from one that happens as soon as the last byte is consumed. Power-down accesses in the middle of a sample, and a write made while the playback push is stalled, show at the ports whether a pointer or a buffer byte was disturbed.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

  // Sample format code: bit 0 selects 16-bit words, bit 1 selects stereo.
  typedef enum logic [1:0] {
    FMT_MONO8    = 2'b00,
    FMT_MONO16   = 2'b01,
    FMT_STEREO8  = 2'b10,
    FMT_STEREO16 = 2'b11
  } smp_fmt_e;

  // Index of the last byte of a sample in the given format.
  function automatic int unsigned fmt_last_idx(input logic [1:0] fmt);
    int unsigned nbytes;
    nbytes = 1 << (int'(fmt[0]) + int'(fmt[1]));
    return nbytes - 1;
  endfunction

  // Value of the data port while powered down: only the top bit set.
  function automatic int unsigned pdn_pattern(input int unsigned byte_w);
    return 1 << (byte_w - 1);
  endfunction

endpackage

// File: rtl/pio_cap_track.sv
module pio_cap_track #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned SMP_BYTES = 4,
  localparam int unsigned IDX_W    = $clog2(SMP_BYTES),
  localparam int unsigned SMP_W    = BYTE_W * SMP_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic              rd_adv,
  input  logic              sts_rd,
  input  logic              fifo_valid,
  input  logic [SMP_W-1:0]  fifo_data,
  output logic              fifo_ready,
  output logic [BYTE_W-1:0] cur_byte,
  output logic [IDX_W-1:0]  idx,
  output logic              fresh
);

  logic [SMP_BYTES-1:0][BYTE_W-1:0] buf_q;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic have_q, have_d;
  logic done_q, done_d;
  logic armed_q, armed_d;
  logic load, advance, at_last;

  // Next-state logic
  always_comb begin
    load    = fifo_valid && (!have_q || (done_q && armed_q));
    advance = rd_adv && have_q && !load;
    at_last = (ptr_q >= last_idx);

    ptr_d   = ptr_q;
    done_d  = done_q;
    armed_d = armed_q;
    have_d  = have_q || load;

    if (load) begin
      ptr_d   = '0;
      done_d  = 1'b0;
      armed_d = 1'b0;
    end else begin
      if (advance) begin
        if (at_last) done_d = 1'b1;
        else         ptr_d  = ptr_q + IDX_W'(1);
      end
      if (sts_rd && done_q) armed_d = 1'b1;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      have_q  <= 1'b0;
      done_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      have_q  <= have_d;
      done_q  <= done_d;
      armed_q <= armed_d;
    end
  end

  // Sample holding register, enabled on load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (load) begin
      buf_q <= fifo_data;
    end
  end

  assign fifo_ready = load;
  assign cur_byte   = buf_q[ptr_q];
  assign idx        = ptr_q;
  assign fresh      = have_q && !done_q;

endmodule

// File: rtl/pio_play_track.sv
module pio_play_track #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned SMP_BYTES = 4,
  localparam int unsigned IDX_W    = $clog2(SMP_BYTES),
  localparam int unsigned SMP_W    = BYTE_W * SMP_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              sts_rd,
  input  logic              fifo_ready,
  output logic              fifo_valid,
  output logic [SMP_W-1:0]  fifo_data,
  output logic              accepting
);

  logic [SMP_BYTES-1:0][BYTE_W-1:0] buf_q, buf_d;
  logic [SMP_BYTES-1:0]             byte_en;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic full_q, full_d;
  logic pend_q, pend_d;
  logic push, wr_ok, at_last;

  always_comb begin
    push    = pend_q && fifo_ready;
    wr_ok   = wr_en && !full_q;
    at_last = (ptr_q >= last_idx);

    ptr_d  = ptr_q;
    full_d = full_q;
    pend_d = pend_q;

    if (push) begin
      ptr_d  = '0;
      full_d = 1'b0;
      pend_d = 1'b0;
    end else begin
      if (wr_ok) begin
        if (at_last) full_d = 1'b1;
        else         ptr_d  = ptr_q + IDX_W'(1);
      end
      if (sts_rd && full_q) pend_d = 1'b1;
    end
  end

  // Per-byte write enables and next values
  for (genvar gi = 0; gi < SMP_BYTES; gi++) begin : g_byte
    always_comb begin
      byte_en[gi] = wr_ok && (ptr_q == IDX_W'(gi));
      if (push)             buf_d[gi] = '0;
      else if (byte_en[gi]) buf_d[gi] = wr_byte;
      else                  buf_d[gi] = buf_q[gi];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      full_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      full_q <= full_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (push || wr_ok) begin
      buf_q <= buf_d;
    end
  end

  assign fifo_valid = pend_q;
  assign fifo_data  = buf_q;
  assign accepting  = !full_q;

endmodule

// File: rtl/pio_host_mux.sv
module pio_host_mux
  import pio_seq_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned SMP_BYTES = 4,
  localparam int unsigned IDX_W    = $clog2(SMP_BYTES),
  localparam logic [BYTE_W-1:0] PDN_VAL = BYTE_W'(pdn_pattern(BYTE_W))
) (
  input  logic              sts_rd,
  input  logic              pdn,
  input  logic [BYTE_W-1:0] cur_byte,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic              cap_fresh,
  input  logic              play_accepting,
  output logic [BYTE_W-1:0] rdata
);

  logic [BYTE_W-1:0] status;

  always_comb begin
    status                 = '0;
    status[IDX_W-1:0]      = cap_idx;
    status[IDX_W]          = cap_fresh;
    status[IDX_W+1]        = play_accepting;
    if (sts_rd)   rdata = status;
    else if (pdn) rdata = PDN_VAL;
    else          rdata = cur_byte;
  end

endmodule

// File: rtl/pio_byte_seq.sv
module pio_byte_seq
  import pio_seq_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned SMP_BYTES = 4,
  localparam int unsigned IDX_W    = $clog2(SMP_BYTES),
  localparam int unsigned SMP_W    = BYTE_W * SMP_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fmt_i,
  input  logic              pdn_i,
  input  logic              dat_rd_i,
  input  logic              dat_wr_i,
  input  logic              sts_rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              cap_valid_i,
  input  logic [SMP_W-1:0]  cap_sample_i,
  output logic              cap_ready_o,
  output logic              play_valid_o,
  output logic [SMP_W-1:0]  play_sample_o,
  input  logic              play_ready_i
);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  logic [IDX_W-1:0]  cap_last;
  logic [IDX_W-1:0]  cap_idx;
  logic [BYTE_W-1:0] cap_byte;
  logic              cap_fresh;
  logic              play_accepting;
  logic              rd_adv, wr_en;

  assign cap_last = IDX_W'(fmt_last_idx(fmt_i));
  assign rd_adv   = dat_rd_i && !pdn_i;
  assign wr_en    = dat_wr_i && !pdn_i;

  pio_cap_track #(.BYTE_W(BYTE_W), .SMP_BYTES(SMP_BYTES)) u_cap (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .last_idx   (cap_last),
    .rd_adv     (rd_adv),
    .sts_rd     (sts_rd_i),
    .fifo_valid (cap_valid_i),
    .fifo_data  (cap_sample_i),
    .fifo_ready (cap_ready_o),
    .cur_byte   (cap_byte),
    .idx        (cap_idx),
    .fresh      (cap_fresh)
  );

  pio_play_track #(.BYTE_W(BYTE_W), .SMP_BYTES(SMP_BYTES)) u_play (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .last_idx   (cap_last),
    .wr_en      (wr_en),
    .wr_byte    (wdata_i),
    .sts_rd     (sts_rd_i),
    .fifo_ready (play_ready_i),
    .fifo_valid (play_valid_o),
    .fifo_data  (play_sample_o),
    .accepting  (play_accepting)
  );

  pio_host_mux #(.BYTE_W(BYTE_W), .SMP_BYTES(SMP_BYTES)) u_mux (
    .sts_rd         (sts_rd_i),
    .pdn            (pdn_i),
    .cur_byte       (cap_byte),
    .cap_idx        (cap_idx),
    .cap_fresh      (cap_fresh),
    .play_accepting (play_accepting),
    .rdata          (rdata_o)
  );

endmodule

// File: rtl/pio_byte_seq_chk.sv
module pio_byte_seq_chk #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned SMP_BYTES = 4,
  localparam int unsigned IDX_W    = $clog2(SMP_BYTES),
  localparam int unsigned SMP_W    = BYTE_W * SMP_BYTES
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pdn_i,
  input logic             dat_rd_i,
  input logic             cap_valid_i,
  input logic             cap_ready_o,
  input logic             play_valid_o,
  input logic             play_ready_i,
  input logic [SMP_W-1:0] play_sample_o,
  input logic [IDX_W-1:0] cap_idx,
  input logic [IDX_W-1:0] cap_last
);

  p_take_needs_offer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ready_o |-> cap_valid_i);

  p_reload_first_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ready_o |=> (cap_idx == '0));

  p_sat_last_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_rd_i && !pdn_i && !cap_ready_o && (cap_idx == cap_last))
      |=> (cap_idx == $past(cap_idx)));

  p_pdn_no_advance_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pdn_i && dat_rd_i && !cap_ready_o) |=> $stable(cap_idx));

  p_push_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (play_valid_o && !play_ready_i) |=> (play_valid_o && $stable(play_sample_o)));

  p_push_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (play_valid_o && play_ready_i) |=> !play_valid_o);

endmodule

bind pio_byte_seq pio_byte_seq_chk #(.BYTE_W(BYTE_W), .SMP_BYTES(SMP_BYTES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_q_n),
  .pdn_i         (pdn_i),
  .dat_rd_i      (dat_rd_i),
  .cap_valid_i   (cap_valid_i),
  .cap_ready_o   (cap_ready_o),
  .play_valid_o  (play_valid_o),
  .play_ready_i  (play_ready_i),
  .play_sample_o (play_sample_o),
  .cap_idx       (cap_idx),
  .cap_last      (cap_last)
);

// File: tb/pio_byte_seq_tb.sv
`timescale 1ns/1ps
module pio_byte_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  fmt;
  logic        pdn, dat_rd, dat_wr, sts_rd;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        cap_valid;
  logic [31:0] cap_sample;
  logic        cap_ready;
  logic        play_valid;
  logic [31:0] play_sample;
  logic        play_ready;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pio_byte_seq u_dut (
    .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .pdn_i(pdn),
    .dat_rd_i(dat_rd), .dat_wr_i(dat_wr), .sts_rd_i(sts_rd),
    .wdata_i(wdata), .rdata_o(rdata),
    .cap_valid_i(cap_valid), .cap_sample_i(cap_sample), .cap_ready_o(cap_ready),
    .play_valid_o(play_valid), .play_sample_o(play_sample), .play_ready_i(play_ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_rd(input logic sts, output logic [7:0] d);
    @(negedge clk);
    sts_rd = sts;
    dat_rd = !sts;
    #1 d = rdata;
    @(posedge clk);
    #1;
    sts_rd = 1'b0;
    dat_rd = 1'b0;
  endtask

  task automatic host_wr(input logic [7:0] b);
    @(negedge clk);
    dat_wr = 1'b1;
    wdata  = b;
    @(posedge clk);
    #1 dat_wr = 1'b0;
  endtask

  task automatic offer(input logic [31:0] s);
    logic taken;
    taken = 1'b0;
    @(negedge clk);
    cap_valid  = 1'b1;
    cap_sample = s;
    for (int i = 0; i < 50 && !taken; i++) begin
      #1;
      if (cap_ready) begin
        @(posedge clk);
        #1 taken = 1'b1;
      end else begin
        @(negedge clk);
      end
    end
    cap_valid = 1'b0;
    chk("R4 sample taken", 32'(taken), 32'd1);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [31:0] smp_a, smp_b, exp_play, smp;
    int nb, idx;

    rst_n = 1'b0; fmt = 2'd3; pdn = 1'b0; dat_rd = 1'b0; dat_wr = 1'b0;
    sts_rd = 1'b0; wdata = '0; cap_valid = 1'b0; cap_sample = '0; play_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // Reset state (R2)
    @(negedge clk); #1;
    chk("R2 reset cap_ready", 32'(cap_ready), 32'd0);
    chk("R9 reset play_valid", 32'(play_valid), 32'd0);
    host_rd(1'b1, d);
    chk("R2 reset status", 32'(d), 32'h08);

    // Reload gated by status read (R3, R4)
    smp_a = 32'hC3C2C1C0;
    smp_b = 32'hD7D6D5D4;
    offer(smp_a);
    for (int k = 0; k < 4; k++) begin
      host_rd(1'b0, d);
      chk("R1 first-sample byte", 32'(d), 32'(smp_a[8*k +: 8]));
    end
    @(negedge clk);
    cap_valid  = 1'b1;
    cap_sample = smp_b;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R4 no take before status read", 32'(cap_ready), 32'd0);
    end
    host_rd(1'b0, d);
    chk("R3 repeat last byte", 32'(d), 32'hC3);
    host_rd(1'b1, d);
    chk("R2 status after drain", 32'(d), 32'h0B);
    @(negedge clk); #1;
    chk("R4 take after status read", 32'(cap_ready), 32'd1);
    @(posedge clk); #1 cap_valid = 1'b0;
    host_rd(1'b1, d);
    chk("R4 status after reload", 32'(d), 32'h0C);
    for (int k = 0; k < 4; k++) begin
      host_rd(1'b0, d);
      chk("R4 new-sample byte", 32'(d), 32'(smp_b[8*k +: 8]));
    end
    host_rd(1'b1, d);
    chk("R2 status drained", 32'(d), 32'h0B);

    // Sweep all formats (R1, R2, R3, R5, R6, R7, R8, R9, R10)
    for (int f = 0; f < 4; f++) begin
      fmt = 2'(f);
      nb  = 1 << ((f & 1) + (f >> 1));
      smp = 32'h11223344 + 32'(f) * 32'h01010101;
      offer(smp);
      for (int k = 0; k < nb + 2; k++) begin
        idx = (k < nb) ? k : nb - 1;
        host_rd(1'b1, d);
        chk("R2 status index/fresh", 32'(d),
            32'h08 | ((k < nb) ? 32'h04 : 32'h00) | 32'(idx));
        host_rd(1'b0, d);
        chk((k < nb) ? "R6 capture byte" : "R5 hold last byte", 32'(d),
            32'(smp[8*idx +: 8]));
        if (f == 3 && k == 1) begin
          pdn = 1'b1;
          host_rd(1'b0, d);
          chk("R10 pdn read value", 32'(d), 32'h80);
          host_rd(1'b1, d);
          chk("R10 pdn read keeps pointer", 32'(d), 32'h0E);
          pdn = 1'b0;
        end
      end

      exp_play = '0;
      for (int k = 0; k < nb + 2; k++) begin
        if (f == 2 && k == 1) begin
          pdn = 1'b1;
          host_wr(8'hFF);
          pdn = 1'b0;
        end
        host_wr(8'(8'hA0 + f * 16 + k));
        if (k < nb) exp_play[8*k +: 8] = 8'(8'hA0 + f * 16 + k);
      end
      host_rd(1'b1, d);
      chk("R8 status full", 32'(d), 32'(nb - 1));
      @(negedge clk); #1;
      chk("R9 push offered", 32'(play_valid), 32'd1);
      chk("R7 playback sample", play_sample, exp_play);
      host_wr(8'h55);
      @(negedge clk); #1;
      chk("R8 write ignored while pending", play_sample, exp_play);
      chk("R9 held while not ready", 32'(play_valid), 32'd1);
      play_ready = 1'b1;
      @(posedge clk); #1 play_ready = 1'b0;
      @(negedge clk); #1;
      chk("R9 push complete", 32'(play_valid), 32'd0);
      host_rd(1'b1, d);
      chk("R9 playback re-armed", 32'(d), 32'h08 | 32'(nb - 1));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule